// File: doc/BRIEF.md
# Frequency and Phase Word Generator

This block turns a synthesizer setting into the binary words that a two-channel direct digital synthesizer core uses. A frequency is entered in whole hertz and becomes a 32-bit tuning word for a 500 MHz sample clock. A phase offset is entered in millidegrees and becomes a 14-bit phase word. The conversion is exact: each word is the integer quotient, rounded to nearest, of a wide numerator. Two sequential restoring dividers produce the quotients, so no rounding error builds up across the range.

Each channel keeps its own tuning and phase word registers. A normal command updates only the selected channel. A coherent command writes one frequency to both channels. Channel 0 gets phase 0 and channel 1 gets the requested offset. Both channels change together under the single update strobe. A frequency outside the legal band is refused: an error flag is raised and the registers are left as they were.

Top module: `tuning_word_gen`

## Requirements
- R1: While reset is asserted and after it is released, busy, err and upd are 0, and all four word outputs are 0.
- R2: A command is taken only in a cycle where cmd_valid is 1 and busy is 0. A command presented while busy is 1 has no effect on any output.
- R3: For an accepted frequency f, the tuning word is floor((f * 2^32 + 250000000) / 500000000), that is, f * 2^32 / 500 MHz rounded half up.
- R4: Legal frequencies run from 100000 Hz to 200000000 Hz, both ends included. A command outside this band sets err to 1 in the next cycle, never raises busy, produces no upd pulse and leaves every word output unchanged.
- R5: err keeps its value until the next command is taken. If that command is in range, err returns to 0 in the cycle that follows.
- R6: For a phase input m below 360000, the phase word is floor((m * 16384 + 180000) / 360000) modulo 16384. Rounding is half up, and values that round to a full turn wrap to 0.
- R7: cmd_phase is 19 bits wide. A value of 360000 or more is first reduced by 360000 and then converted as in R6.
- R8: For a command with cmd_coherent = 0, only the channel selected by cmd_chan (0 selects ftw0/pw0, 1 selects ftw1/pw1) is updated. The other channel's words stay the same.
- R9: For a command with cmd_coherent = 1 (cmd_chan ignored), ftw0 and ftw1 both receive the tuning word, pw0 becomes 0 and pw1 receives the phase word. All of this happens in the cycle of a single upd pulse.
- R10: busy is 1 from the clock edge that takes a command until upd rises. upd is high for exactly one cycle, starting at the 33rd rising edge after the accepting edge. busy is 0 while upd is 1.
- R11: The word outputs change only at the edge that raises upd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_chan | input | 1 | Target channel for a non-coherent command |
| cmd_coherent | input | 1 | Load both channels with a relative phase |
| cmd_freq | input | 28 | Frequency in hertz |
| cmd_phase | input | 19 | Phase offset in millidegrees |
| busy | output | 1 | Conversion in progress |
| err | output | 1 | Last command was out of range |
| upd | output | 1 | One-cycle update strobe |
| ftw0 | output | 32 | Channel 0 tuning word |
| ftw1 | output | 32 | Channel 1 tuning word |
| pw0 | output | 14 | Channel 0 phase word |
| pw1 | output | 14 | Channel 1 phase word |

## Verification
The frequency path is tried at both band edges and at a mid-band value. These cases separate a correct round-half-up quotient from a truncating one and from an off-by-one in the range check. A value one hertz outside each edge shows the rejection path, and the error flag then clears on a good command. The phase path is tried at 10 and 11 millidegrees, which lie on either side of a rounding step. It is also tried at 359999, which must wrap to 0, and at inputs above a full turn, which expose a missing modulo reduction. Separate-channel, coherent and mid-conversion commands show which registers are written and when.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} tpg_state_e;
  localparam int unsigned MDEG_TURN = 360000;
endpackage

// File: rtl/tpg_rdiv.sv
// Sequential restoring divider by a constant: one quotient bit per cycle.
// Requires num[DW+QW-1:QW] < DEN.
module tpg_rdiv #(
  parameter int unsigned     DW  = 29,
  parameter int unsigned     QW  = 32,
  parameter longint unsigned DEN = 500000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW+QW-1:0]  num,
  output logic              busy,
  output logic [QW-1:0]     quo
);
  localparam int unsigned CW = $clog2(QW + 1);
  localparam logic [DW:0] DEN_X = (DW+1)'(DEN);

  logic [DW-1:0] rem_q, rem_d;
  logic [QW-1:0] quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic [DW:0]   trial, diff;
  logic          ge, en;

  always_comb begin
    trial  = {rem_q, quo_q[QW-1]};
    diff   = trial - DEN_X;
    ge     = (trial >= DEN_X);
    en     = start | busy_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      rem_d  = num[DW+QW-1:QW];
      quo_d  = num[QW-1:0];
      cnt_d  = CW'(QW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d  = ge ? diff[DW-1:0] : trial[DW-1:0];
      quo_d  = {quo_q[QW-2:0], ge};
      cnt_d  = cnt_q - 1'b1;
      busy_d = (cnt_q != CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign quo  = quo_q;
endmodule

// File: rtl/tpg_chan_reg.sv
module tpg_chan_reg #(
  parameter int unsigned FTW_W = 32,
  parameter int unsigned PH_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [FTW_W-1:0] ftw_in,
  input  logic [PH_W-1:0]  pw_in,
  output logic [FTW_W-1:0] ftw,
  output logic [PH_W-1:0]  pw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw <= '0;
      pw  <= '0;
    end else if (wr) begin
      ftw <= ftw_in;
      pw  <= pw_in;
    end
  end
endmodule

// File: rtl/tuning_word_gen.sv
module tuning_word_gen
  import tpg_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 500000000,
  parameter int unsigned     FREQ_W = 28,
  parameter int unsigned     FMIN   = 100000,
  parameter int unsigned     FMAX   = 200000000,
  parameter int unsigned     FTW_W  = 32,
  parameter int unsigned     PH_W   = 14,
  parameter int unsigned     MDEG_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_chan,
  input  logic              cmd_coherent,
  input  logic [FREQ_W-1:0] cmd_freq,
  input  logic [MDEG_W-1:0] cmd_phase,
  output logic              busy,
  output logic              err,
  output logic              upd,
  output logic [FTW_W-1:0]  ftw0,
  output logic [FTW_W-1:0]  ftw1,
  output logic [PH_W-1:0]   pw0,
  output logic [PH_W-1:0]   pw1
);
  localparam int unsigned FDEN_W = $clog2(CLK_HZ + 1);
  localparam int unsigned FNUM_W = FDEN_W + FTW_W;
  localparam int unsigned PDEN_W = $clog2(MDEG_TURN + 1);
  localparam int unsigned PQ_W   = PH_W + 1;
  localparam int unsigned PNUM_W = PDEN_W + PQ_W;
  localparam int unsigned NCH    = 2;

  tpg_state_e          state_q, state_d;
  logic                chan_q, coh_q, err_q, err_d, upd_q;
  logic                accept, in_range, go, fin;
  logic                fbusy, pbusy;
  logic [MDEG_W-1:0]   mdeg_red;
  logic [FNUM_W-1:0]   fnum;
  logic [PNUM_W-1:0]   pnum;
  logic [FTW_W-1:0]    fquo;
  logic [PQ_W-1:0]     pquo;
  logic [FTW_W-1:0]    ftw_o [NCH];
  logic [PH_W-1:0]     pw_o  [NCH];

  always_comb begin
    accept   = cmd_valid & (state_q == ST_IDLE);
    in_range = (cmd_freq >= FREQ_W'(FMIN)) && (cmd_freq <= FREQ_W'(FMAX));
    go       = accept & in_range;
    mdeg_red = (cmd_phase >= MDEG_W'(MDEG_TURN)) ? (cmd_phase - MDEG_W'(MDEG_TURN)) : cmd_phase;
    fnum     = (FNUM_W'(cmd_freq) << FTW_W) + FNUM_W'(CLK_HZ / 2);
    pnum     = (PNUM_W'(mdeg_red) << PH_W) + PNUM_W'(MDEG_TURN / 2);
    fin      = (state_q == ST_RUN) & ~fbusy & ~pbusy;
    err_d    = accept ? ~in_range : err_q;
    state_d  = state_q;
    case (state_q)
      ST_IDLE: if (go)  state_d = ST_RUN;
      ST_RUN:  if (fin) state_d = ST_IDLE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      upd_q   <= 1'b0;
      chan_q  <= 1'b0;
      coh_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      upd_q   <= fin;
      if (go) begin
        chan_q <= cmd_chan;
        coh_q  <= cmd_coherent;
      end
    end
  end

  tpg_rdiv #(.DW(FDEN_W), .QW(FTW_W), .DEN(CLK_HZ)) u_fdiv (
    .clk(clk), .rst_n(rst_n), .start(go), .num(fnum), .busy(fbusy), .quo(fquo)
  );

  tpg_rdiv #(.DW(PDEN_W), .QW(PQ_W), .DEN(longint'(MDEG_TURN))) u_pdiv (
    .clk(clk), .rst_n(rst_n), .start(go), .num(pnum), .busy(pbusy), .quo(pquo)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic            wr;
    logic [PH_W-1:0] pw_in;
    always_comb begin
      wr    = fin & (coh_q | (chan_q == 1'(c)));
      pw_in = (coh_q && (c == 0)) ? '0 : pquo[PH_W-1:0];
    end
    tpg_chan_reg #(.FTW_W(FTW_W), .PH_W(PH_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr(wr), .ftw_in(fquo), .pw_in(pw_in),
      .ftw(ftw_o[c]), .pw(pw_o[c])
    );
  end

  assign busy = (state_q == ST_RUN);
  assign err  = err_q;
  assign upd  = upd_q;
  assign ftw0 = ftw_o[0];
  assign ftw1 = ftw_o[1];
  assign pw0  = pw_o[0];
  assign pw1  = pw_o[1];
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
  parameter int unsigned FTW_W = 32,
  parameter int unsigned PH_W  = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             busy,
  input logic             err,
  input logic             upd,
  input logic [FTW_W-1:0] ftw0,
  input logic [FTW_W-1:0] ftw1,
  input logic [PH_W-1:0]  pw0,
  input logic [PH_W-1:0]  pw1
);
  // R10
  upd_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) upd |-> !busy);
  // R10
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n) upd |=> !upd);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cmd_valid));
  // R4
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> !busy);
  // R11
  words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ftw0) || !$stable(ftw1) || !$stable(pw0) || !$stable(pw1)) |-> upd);
endmodule

bind tuning_word_gen tpg_chk #(.FTW_W(FTW_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .err(err),
  .upd(upd), .ftw0(ftw0), .ftw1(ftw1), .pw0(pw0), .pw1(pw1)
);

// File: tb/tuning_word_gen_test.sv
module tuning_word_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_chan = 1'b0;
  logic        cmd_coherent = 1'b0;
  logic [27:0] cmd_freq = '0;
  logic [18:0] cmd_phase = '0;
  logic        busy, err, upd;
  logic [31:0] ftw0, ftw1;
  logic [13:0] pw0, pw1;

  int vectors = 0;
  int fails   = 0;
  logic [31:0] m_ftw [2];
  logic [13:0] m_pw  [2];

  always #10 clk = ~clk;

  tuning_word_gen uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
    .cmd_coherent(cmd_coherent), .cmd_freq(cmd_freq), .cmd_phase(cmd_phase),
    .busy(busy), .err(err), .upd(upd), .ftw0(ftw0), .ftw1(ftw1), .pw0(pw0), .pw1(pw1)
  );

  function automatic logic [31:0] exp_ftw(input int unsigned f);
    longint unsigned n = (longint'(f) << 32) + 64'd250000000;
    return 32'(n / 64'd500000000);
  endfunction

  function automatic logic [13:0] exp_pw(input int unsigned m);
    int unsigned r = (m >= 360000) ? m - 360000 : m;
    longint unsigned n = longint'(r) * 64'd16384 + 64'd180000;
    return 14'(n / 64'd360000);
  endfunction

  task automatic chk(input longint unsigned act, input longint unsigned exp, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic chk_words(input string tag);
    chk(ftw0, m_ftw[0], {tag, " ftw0"});
    chk(ftw1, m_ftw[1], {tag, " ftw1"});
    chk(pw0,  m_pw[0],  {tag, " pw0"});
    chk(pw1,  m_pw[1],  {tag, " pw1"});
  endtask

  // drive for one edge; returns at the negedge after the accepting edge
  task automatic send(input logic ch, input logic coh, input int unsigned f, input int unsigned m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_chan = ch; cmd_coherent = coh;
    cmd_freq = 28'(f); cmd_phase = 19'(m);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_upd(output int k);
    k = 0;
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (upd) begin k = i; break; end
    end
  endtask

  task automatic t_reset();
    // R1
    chk(busy, 0, "R1 busy"); chk(err, 0, "R1 err"); chk(upd, 0, "R1 upd");
    chk_words("R1");
  endtask

  task automatic t_single(input logic ch, input int unsigned f, input int unsigned m, input string tag);
    int k;
    send(ch, 1'b0, f, m);
    chk(busy, 1, {tag, " R10 busy after accept"});
    wait_upd(k);
    chk(k, 33, {tag, " R10 latency"});
    chk(busy, 0, {tag, " R10 busy low at upd"});
    m_ftw[ch] = exp_ftw(f);
    m_pw[ch]  = exp_pw(m);
    chk_words({tag, " R3 R6 R8"});
    @(negedge clk);
    chk(upd, 0, {tag, " R10 upd one cycle"});
  endtask

  task automatic t_coherent(input int unsigned f, input int unsigned m);
    int k;
    send(1'b0, 1'b1, f, m);
    wait_upd(k);
    chk(k, 33, "R9 latency");
    m_ftw[0] = exp_ftw(f); m_ftw[1] = exp_ftw(f);
    m_pw[0]  = '0;         m_pw[1]  = exp_pw(m);
    chk_words("R9 coherent");
    @(negedge clk);
    chk(upd, 0, "R9 single strobe");
  endtask

  task automatic t_reject(input int unsigned f);
    int k;
    send(1'b1, 1'b0, f, 1000);
    chk(busy, 0, "R4 busy stays low");
    chk(err, 1, "R4 err set");
    k = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (upd) k++;
    end
    chk(k, 0, "R4 no strobe");
    chk(err, 1, "R5 err held");
    chk_words("R4 unchanged");
  endtask

  task automatic t_err_clear();
    int k;
    send(1'b0, 1'b0, 1000000, 45000);
    chk(err, 0, "R5 err cleared");
    wait_upd(k);
    m_ftw[0] = exp_ftw(1000000); m_pw[0] = exp_pw(45000);
    chk_words("R5 good after reject");
  endtask

  task automatic t_busy_ignore();
    int k, extra;
    send(1'b0, 1'b0, 7000000, 120000);
    repeat (4) @(negedge clk);
    cmd_valid = 1'b1; cmd_chan = 1'b1; cmd_coherent = 1'b1;
    cmd_freq = 28'd150000000; cmd_phase = 19'd200000;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk_words("R11 hold mid conversion");
    k = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (upd) begin k = i; break; end
    end
    chk(k, 28, "R2 first command completes on time");
    m_ftw[0] = exp_ftw(7000000); m_pw[0] = exp_pw(120000);
    chk_words("R2 busy command ignored");
    extra = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (upd) extra++;
    end
    chk(extra, 0, "R2 no second conversion");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    m_ftw[0] = '0; m_ftw[1] = '0; m_pw[0] = '0; m_pw[1] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(1'b0, 100000, 0, "low edge");
    t_single(1'b1, 200000000, 90000, "high edge");
    t_single(1'b0, 14074000, 11, "mid R6 round up");
    t_single(1'b1, 3579545, 10, "R6 round down");
    t_single(1'b0, 123456789, 359999, "R6 wrap");
    t_single(1'b1, 50000000, 450000, "R7 reduce");
    t_single(1'b0, 100001, 524287, "R7 top input");
    t_reject(99999);
    t_reject(200000001);
    t_err_clear();
    t_coherent(10000000, 90000);
    t_coherent(199999999, 270001);
    t_busy_ignore();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule